// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block takes an SDRAM device from reset to normal operation. A start pulse launches a fixed script of precharge-all, auto-refresh and mode-register load commands. Each command appears as a single-cycle one-hot strobe, and each load strobe carries a 13-bit mode value. Two scripts are held in the block. A memory-type strap chooses between them: a second-generation (DDR2) script and a first-generation (DDR1) script. The DDR2 script includes a DLL reset and an off-chip-driver calibration default followed by a calibration exit.

For the DDR2 script, a configuration word is published before the first command is issued. When the last command has been issued, the block publishes a refresh control word that turns periodic refresh on. A reference-clock strap selects the refresh interval. The block then holds its init-done flag high until reset. The straps are sampled only when the start pulse is accepted. Consecutive commands are spaced by a parameterized number of cycles.

The controller is built around five states:
- `ST_IDLE` waits for a start pulse. A start pulse moves it to `ST_SETUP`.
- `ST_SETUP` latches the straps and loads the DDR2 configuration word. It always moves to `ST_GAP`.
- `ST_GAP` waits for the spacing timer. When the timer expires it moves to `ST_ISSUE`.
- `ST_ISSUE` drives one strobe. It moves to `ST_GAP` while script entries remain, and to `ST_DONE` after the last entry.
- `ST_DONE` is terminal until reset.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, `cmd_strobe_o`, `mode_val_o`, `ddr2_cfg_o` and `refresh_ctl_o` are zero, and `init_done_o` and `busy_o` are low. No strobe appears until a start pulse is accepted.
- R2: The command strobe has at most one bit high. The bits are: bit0 = load MR, bit1 = load EMR, bit2 = auto-refresh, bit3 = precharge-all, bit4 = load EMR2, bit5 = load EMR3. `mode_val_o` carries the mode value during a load strobe and is zero otherwise.
- R3: When `strap_ddr2_i` is 1, the script is 11 commands long:
  - precharge-all
  - EMR2=0x000
  - EMR3=0x000
  - EMR=0x000
  - MR=0x100
  - precharge-all
  - auto-refresh
  - auto-refresh
  - MR=0xA33
  - EMR=0x382
  - EMR=0x402
- R4: When `strap_ddr2_i` is 0, the script is 5 commands long:
  - precharge-all
  - MR=0x133
  - EMR=0x002
  - precharge-all
  - MR=0x033
- R5: Consecutive strobes are exactly `GAP_CYCLES` clock cycles apart (default 16).
- R6: In DDR2 mode, `ddr2_cfg_o` equals 0x0A59 before the first strobe is issued. The fields are: bit0 enable, bits 7:2 tFAW = 22, bit9 ODT on, bits 13:10 write latency = 2. In DDR1 mode, `ddr2_cfg_o` stays 0.
- R7: Once the script completes, `refresh_ctl_o` has bit14 (enable) set and bits 9:0 holding the interval. The interval is 624 (word 0x4270) with `strap_ref40_i`=1, and 390 (word 0x4186) otherwise.
- R8: `init_done_o` rises one cycle after the last strobe and stays high until reset. A start pulse after completion produces no strobe.
- R9: A start pulse while the sequence is running is ignored. The script continues unchanged and is not restarted.
- R10: The straps are sampled only when the start pulse is accepted. Changing them mid-sequence alters neither the script, the configuration word nor the refresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only in idle |
| strap_ddr2_i | input | 1 | 1 selects the DDR2 script, 0 the DDR1 script |
| strap_ref40_i | input | 1 | 1 selects the 40 MHz reference refresh interval |
| cmd_strobe_o | output | 6 | One-hot command strobe, one cycle per command |
| mode_val_o | output | 13 | Mode value accompanying a load strobe |
| ddr2_cfg_o | output | 14 | DDR2 configuration word (enable, tFAW, ODT, write latency) |
| refresh_ctl_o | output | 16 | Refresh control word: bit14 enable, bits 9:0 interval |
| busy_o | output | 1 | High while the script is running |
| init_done_o | output | 1 | Sticky completion flag |

## Verification
The hardest situation to reach from the ports is a disturbance in the middle of a running script. This means a second start pulse arriving together with both straps flipping after some commands have already been issued. From outside, this must leave no trace. The directed scenario watches the strobe log and waits for the second strobe. At that point it pulses start and inverts both straps. It then compares the complete log, the spacing, the configuration word and the refresh word against the script selected by the original straps. A further scenario pulses start after completion and confirms that the strobe log does not grow.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam int CMD_W    = 6;
    localparam int MODE_W   = 13;
    localparam int CFG_W    = 14;
    localparam int REFW_W   = 16;
    localparam int INTV_W   = 10;
    localparam int SCRIPT_MAX = 11;
    localparam int IDX_W    = $clog2(SCRIPT_MAX);

    // one-hot strobe bit positions (decoded by the command encoder downstream)
    localparam int B_LD_MR   = 0;
    localparam int B_LD_EMR  = 1;
    localparam int B_AREF    = 2;
    localparam int B_PREALL  = 3;
    localparam int B_LD_EMR2 = 4;
    localparam int B_LD_EMR3 = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_GAP,
        ST_ISSUE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [MODE_W-1:0] mode;
        logic              last;
    } script_entry_t;

endpackage

// File: rtl/init_script_rom.sv
module init_script_rom
    import sdram_init_pkg::*;
(
    input  logic                 ddr2_i,
    input  logic [IDX_W-1:0]     idx_i,
    output script_entry_t        entry_o
);

    function automatic script_entry_t mk(input int bitpos, input logic [MODE_W-1:0] m,
                                         input logic lst);
        script_entry_t e;
        e.cmd  = CMD_W'(1) << bitpos;
        e.mode = m;
        e.last = lst;
        return e;
    endfunction

    function automatic script_entry_t gen2_step(input logic [IDX_W-1:0] i);
        script_entry_t e;
        unique case (i)
            4'd0:    e = mk(B_PREALL,  13'h000, 1'b0);
            4'd1:    e = mk(B_LD_EMR2, 13'h000, 1'b0);
            4'd2:    e = mk(B_LD_EMR3, 13'h000, 1'b0);
            4'd3:    e = mk(B_LD_EMR,  13'h000, 1'b0);
            4'd4:    e = mk(B_LD_MR,   13'h100, 1'b0);
            4'd5:    e = mk(B_PREALL,  13'h000, 1'b0);
            4'd6:    e = mk(B_AREF,    13'h000, 1'b0);
            4'd7:    e = mk(B_AREF,    13'h000, 1'b0);
            4'd8:    e = mk(B_LD_MR,   13'hA33, 1'b0);
            4'd9:    e = mk(B_LD_EMR,  13'h382, 1'b0);
            default: e = mk(B_LD_EMR,  13'h402, 1'b1);
        endcase
        return e;
    endfunction

    function automatic script_entry_t gen1_step(input logic [IDX_W-1:0] i);
        script_entry_t e;
        unique case (i)
            4'd0:    e = mk(B_PREALL,  13'h000, 1'b0);
            4'd1:    e = mk(B_LD_MR,   13'h133, 1'b0);
            4'd2:    e = mk(B_LD_EMR,  13'h002, 1'b0);
            4'd3:    e = mk(B_PREALL,  13'h000, 1'b0);
            default: e = mk(B_LD_MR,   13'h033, 1'b1);
        endcase
        return e;
    endfunction

    always_comb begin
        entry_o = ddr2_i ? gen2_step(idx_i) : gen1_step(idx_i);
    end

endmodule

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
    parameter int GAP_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(GAP_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP_CYCLES - 2);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    p_reload_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= RELOAD);

endmodule

// File: rtl/init_cfg_regs.sv
module init_cfg_regs
    import sdram_init_pkg::*;
#(
    parameter int REF_INT_FAST = 624,
    parameter int REF_INT_SLOW = 390,
    parameter int DDR2_WL      = 2,
    parameter int DDR2_TFAW    = 22,
    parameter bit DDR2_ODT     = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ddr2_load_i,
    input  logic              ref_load_i,
    input  logic              ref40_i,
    output logic [CFG_W-1:0]  ddr2_cfg_o,
    output logic [REFW_W-1:0] refresh_ctl_o
);

    localparam int REF_EN_BIT = 14;

    logic [CFG_W-1:0]  cfg_word;
    logic [REFW_W-1:0] ref_word;
    logic [CFG_W-1:0]  cfg_q;
    logic [REFW_W-1:0] ref_q;

    always_comb begin
        cfg_word        = '0;
        cfg_word[0]     = 1'b1;
        cfg_word[7:2]   = 6'(DDR2_TFAW);
        cfg_word[9]     = DDR2_ODT;
        cfg_word[13:10] = 4'(DDR2_WL);

        ref_word               = '0;
        ref_word[REF_EN_BIT]   = 1'b1;
        ref_word[INTV_W-1:0]   = ref40_i ? INTV_W'(REF_INT_FAST) : INTV_W'(REF_INT_SLOW);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '0;
            ref_q <= '0;
        end else begin
            if (ddr2_load_i) cfg_q <= cfg_word;
            if (ref_load_i)  ref_q <= ref_word;
        end
    end

    assign ddr2_cfg_o    = cfg_q;
    assign refresh_ctl_o = ref_q;

    p_ref_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_q[REF_EN_BIT] |=> ref_q[REF_EN_BIT] && $stable(ref_q));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int GAP_CYCLES   = 16,
    parameter int REF_INT_FAST = 624,
    parameter int REF_INT_SLOW = 390
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              strap_ddr2_i,
    input  logic              strap_ref40_i,
    output logic [CMD_W-1:0]  cmd_strobe_o,
    output logic [MODE_W-1:0] mode_val_o,
    output logic [CFG_W-1:0]  ddr2_cfg_o,
    output logic [REFW_W-1:0] refresh_ctl_o,
    output logic              busy_o,
    output logic              init_done_o
);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             ddr2_q;
    logic             ref40_q;
    script_entry_t    entry;
    logic             gap_load;
    logic             gap_expired;
    logic             finish;

    init_script_rom u_rom (
        .ddr2_i  (ddr2_q),
        .idx_i   (idx_q),
        .entry_o (entry)
    );

    init_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (gap_load),
        .expired_o (gap_expired)
    );

    init_cfg_regs #(
        .REF_INT_FAST (REF_INT_FAST),
        .REF_INT_SLOW (REF_INT_SLOW)
    ) u_cfg (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .ddr2_load_i   ((state_q == ST_SETUP) && ddr2_q),
        .ref_load_i    (finish),
        .ref40_i       (ref40_q),
        .ddr2_cfg_o    (ddr2_cfg_o),
        .refresh_ctl_o (refresh_ctl_o)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SETUP;
            ST_SETUP: state_d = ST_GAP;
            ST_GAP:   if (gap_expired) state_d = ST_ISSUE;
            ST_ISSUE: state_d = entry.last ? ST_DONE : ST_GAP;
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and sequence bookkeeping
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            ddr2_q  <= 1'b0;
            ref40_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                ddr2_q  <= strap_ddr2_i;
                ref40_q <= strap_ref40_i;
                idx_q   <= '0;
            end else if (state_q == ST_ISSUE && !entry.last) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_strobe_o = '0;
        mode_val_o   = '0;
        gap_load     = 1'b0;
        finish       = 1'b0;
        busy_o       = 1'b0;
        init_done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SETUP: begin
                busy_o   = 1'b1;
                gap_load = 1'b1;
            end
            ST_GAP: busy_o = 1'b1;
            ST_ISSUE: begin
                busy_o       = 1'b1;
                cmd_strobe_o = entry.cmd;
                mode_val_o   = (entry.cmd[B_AREF] || entry.cmd[B_PREALL]) ? '0 : entry.mode;
                gap_load     = !entry.last;
                finish       = entry.last;
            end
            ST_DONE: init_done_o = 1'b1;
            default: ;
        endcase
    end

    // spacing checker: cycles since the previous strobe, saturating
    localparam int SW = $clog2(GAP_CYCLES + 1);
    logic [SW-1:0] since_q;
    logic          seen_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (cmd_strobe_o != '0) begin
            since_q <= SW'(1);
            seen_q  <= 1'b1;
        end else if (since_q < SW'(GAP_CYCLES)) begin
            since_q <= since_q + 1'b1;
        end
    end

    p_strobe_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(cmd_strobe_o));
    p_strobe_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_strobe_o != '0 && seen_q) |-> since_q == SW'(GAP_CYCLES));
    p_cfg_before_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_strobe_o != '0) |-> (ddr2_cfg_o[0] == ddr2_q));
    p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_done_o |=> init_done_o);
    p_quiet_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_done_o |-> (cmd_strobe_o == '0 && !busy_o));
    p_refresh_on_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_done_o |-> refresh_ctl_o[14]);
    p_straps_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> ($stable(ddr2_q) && $stable(ref40_q)));

endmodule

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;

    localparam int GAP = 16;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic        strap_ddr2_i = 1'b0;
    logic        strap_ref40_i = 1'b0;
    logic [5:0]  cmd_strobe_o;
    logic [12:0] mode_val_o;
    logic [13:0] ddr2_cfg_o;
    logic [15:0] refresh_ctl_o;
    logic        busy_o;
    logic        init_done_o;

    always #2 clk = ~clk;

    sdram_init_seq #(.GAP_CYCLES(GAP)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
        .strap_ddr2_i(strap_ddr2_i), .strap_ref40_i(strap_ref40_i),
        .cmd_strobe_o(cmd_strobe_o), .mode_val_o(mode_val_o),
        .ddr2_cfg_o(ddr2_cfg_o), .refresh_ctl_o(refresh_ctl_o),
        .busy_o(busy_o), .init_done_o(init_done_o)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // strobe logger, sampled at the falling edge
    int         cyc = 0;
    int         log_n = 0;
    logic [5:0]  log_cmd  [0:63];
    logic [12:0] log_mode [0:63];
    logic [13:0] log_cfg  [0:63];
    int          log_cyc  [0:63];
    int          done_cyc = -1;
    logic        done_prev = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        done_prev <= init_done_o;
        if (init_done_o && !done_prev) done_cyc <= cyc;
        if (cmd_strobe_o != 6'd0 && log_n < 64) begin
            log_cmd[log_n]  <= cmd_strobe_o;
            log_mode[log_n] <= mode_val_o;
            log_cfg[log_n]  <= ddr2_cfg_o;
            log_cyc[log_n]  <= cyc;
            log_n <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // expected scripts, encoding: MR=1 EMR=2 AREF=4 PRE=8 EMR2=16 EMR3=32
    function automatic int exp_len(input bit d2);
        return d2 ? 11 : 5;
    endfunction

    function automatic logic [5:0] exp_cmd(input bit d2, input int i);
        logic [5:0] g2 [0:10] = '{6'd8, 6'd16, 6'd32, 6'd2, 6'd1, 6'd8, 6'd4, 6'd4,
                                   6'd1, 6'd2, 6'd2};
        logic [5:0] g1 [0:4]  = '{6'd8, 6'd1, 6'd2, 6'd8, 6'd1};
        return d2 ? g2[i] : g1[i];
    endfunction

    function automatic logic [12:0] exp_mode(input bit d2, input int i);
        logic [12:0] g2 [0:10] = '{13'h0, 13'h0, 13'h0, 13'h0, 13'h100, 13'h0, 13'h0,
                                   13'h0, 13'hA33, 13'h382, 13'h402};
        logic [12:0] g1 [0:4]  = '{13'h0, 13'h133, 13'h002, 13'h0, 13'h033};
        return d2 ? g2[i] : g1[i];
    endfunction

    task automatic do_reset();
        @(posedge clk); #1;
        rst_ni = 1'b0; start_i = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_ni = 1'b1;
    endtask

    task automatic test_reset();
        do_reset();
        repeat (2) @(negedge clk);
        check(cmd_strobe_o == 0 && mode_val_o == 0, "R1 strobe/mode idle",
              {13'd0, cmd_strobe_o, mode_val_o}, 0);
        check(ddr2_cfg_o == 0 && refresh_ctl_o == 0, "R1 cfg/refresh words",
              {ddr2_cfg_o, refresh_ctl_o}, 0);
        check(!init_done_o && !busy_o, "R1 done/busy low", {init_done_o, busy_o}, 0);
        begin
            int base = log_n;
            repeat (3 * GAP) @(negedge clk);
            check(log_n == base, "R1 no strobe without start", log_n - base, 0);
        end
    endtask

    task automatic run_case(input bit d2, input bit r40, input bit mid_start,
                            input bit late_start);
        int  base;
        bit  pulsed = 0;
        int  wait_n = 0;
        do_reset();
        strap_ddr2_i = d2; strap_ref40_i = r40;
        @(negedge clk);
        base = log_n;
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        while (!init_done_o && wait_n < 1000) begin
            @(posedge clk); #1;
            wait_n++;
            if (mid_start && !pulsed && log_n >= base + 2) begin
                // R9 / R10: restart attempt with flipped straps
                start_i = 1'b1; strap_ddr2_i = !d2; strap_ref40_i = !r40;
                pulsed = 1;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        check(init_done_o, "R8 sequence completes", init_done_o, 1);
        repeat (2) @(negedge clk);
        check(log_n - base == exp_len(d2), d2 ? "R3 script length" : "R4 script length",
              log_n - base, exp_len(d2));
        for (int i = 0; i < exp_len(d2) && base + i < log_n; i++) begin
            check(log_cmd[base+i] == exp_cmd(d2, i) && log_mode[base+i] == exp_mode(d2, i),
                  d2 ? "R3 command/mode entry" : "R4 command/mode entry",
                  {log_cmd[base+i], log_mode[base+i]}, {exp_cmd(d2, i), exp_mode(d2, i)});
            check($countones(log_cmd[base+i]) == 1, "R2 one-hot strobe",
                  log_cmd[base+i], exp_cmd(d2, i));
            if (i > 0)
                check(log_cyc[base+i] - log_cyc[base+i-1] == GAP, "R5 strobe spacing",
                      log_cyc[base+i] - log_cyc[base+i-1], GAP);
        end
        if (log_n > base) begin
            check(log_cfg[base] == (d2 ? 14'h0A59 : 14'h0), "R6 cfg at first strobe",
                  log_cfg[base], d2 ? 14'h0A59 : 14'h0);
            check(done_cyc == log_cyc[log_n-1] + 1, "R8 done one cycle after last",
                  done_cyc, log_cyc[log_n-1] + 1);
        end
        check(ddr2_cfg_o == (d2 ? 14'h0A59 : 14'h0), mid_start ? "R10 cfg word" : "R6 cfg word",
              ddr2_cfg_o, d2 ? 14'h0A59 : 14'h0);
        check(refresh_ctl_o == (r40 ? 16'h4270 : 16'h4186),
              mid_start ? "R10 refresh word" : "R7 refresh word",
              refresh_ctl_o, r40 ? 16'h4270 : 16'h4186);
        if (mid_start)
            check(pulsed && log_n - base == exp_len(d2), "R9 mid-run start ignored",
                  log_n - base, exp_len(d2));
        if (late_start) begin
            base = log_n;
            @(posedge clk); #1 start_i = 1'b1;
            @(posedge clk); #1 start_i = 1'b0;
            repeat (3 * GAP) @(negedge clk);
            check(log_n == base, "R8 start after done ignored", log_n - base, 0);
            check(init_done_o, "R8 done stays high", init_done_o, 1);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        test_reset();
        run_case(1'b1, 1'b1, 1'b0, 1'b0);
        run_case(1'b0, 1'b0, 1'b0, 1'b0);
        run_case(1'b1, 1'b0, 1'b1, 1'b0);
        run_case(1'b0, 1'b1, 1'b1, 1'b1);
        do_reset();
        repeat (2) @(negedge clk);
        check(!init_done_o && refresh_ctl_o == 0, "R1 reset clears done and refresh",
              {init_done_o, refresh_ctl_o}, 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule